// File: doc/BRIEF.md
# PCM Byte Serializer with FIFO Fetch

This block turns a sequence of bytes held in an external first-word-fall-through FIFO into a continuous serial PCM bit stream. A bit clock and a word clock arrive from an outside divider and are sampled by the system clock. The word clock is low for one bit slot in every eight, and that slot is the gap between bytes. The block produces four things from these two clocks: the FIFO read strobe, an active-low parallel-load enable, a bit-sync output and a word-sync output. The strobe and the load are plain gates on the two clocks. During the low half of the gap slot the next byte is taken from the FIFO head into the shift register. It then leaves the serial output most significant bit first, one bit per bit-clock rising edge.

When the FIFO reports empty at the moment a byte is taken, the block sends a byte of all ones instead. It also raises a sticky underrun flag, which stays set until a clear pulse arrives.

Top module: `pcm_byte_serializer`

## Requirements
- R1: `bit_sync_o` always equals `bit_clk_i`.
- R2: `word_sync_o` always equals `word_clk_i`, with the same polarity.
- R3: `fifo_rd_o` is the inverse of `word_clk_i`. It is high for the whole gap slot, and the FIFO head is consumed on its falling edge.
- R4: `load_n_o` is low exactly while both `word_clk_i` and `bit_clk_i` are low, and high otherwise.
- R5: `sdata_o` changes only on the system clock edge where a bit-clock rise is first seen. It holds its value for the rest of the bit slot.
- R6: The word on `fifo_data_i` is captured on the first system clock edge of a load window. It appears on `sdata_o` most significant bit first. The first bit appears at the next bit-clock rise, and one bit follows at each rise, so eight bits fill the eight slots.
- R7: When `fifo_empty_i` is high at capture, the byte sent is 8'hFF and `underrun_o` becomes 1 on that same edge.
- R8: `underrun_o` stays set until `underrun_clr_i` is high on a clock edge. It then reads 0 from the next cycle, unless an empty capture happens on that same edge. The flag does not rise while the FIFO keeps data.
- R9: In reset, `sdata_o` is 1 and `underrun_o` is 0. The shift register holds all ones, so the line idles high until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Bit clock, sampled by clk |
| word_clk_i | input | 1 | Word clock, low during the gap slot |
| fifo_data_i | input | WIDTH | Byte at the FIFO head |
| fifo_empty_i | input | 1 | FIFO empty flag |
| underrun_clr_i | input | 1 | Clears the underrun flag |
| fifo_rd_o | output | 1 | FIFO read strobe (inverted word clock) |
| load_n_o | output | 1 | Active-low parallel-load enable |
| sdata_o | output | 1 | Serial PCM data |
| bit_sync_o | output | 1 | Bit-sync copy of the bit clock |
| word_sync_o | output | 1 | Word-sync copy of the word clock |
| underrun_o | output | 1 | Sticky FIFO underrun flag |

## Verification
A shift register with bad contents or a misplaced load shows up on `sdata_o` within the next byte. The whole eight-bit word assembled after a word-sync rise then differs from the FIFO byte queued at its load window. A missed or doubled bit-clock edge moves every later bit, so the error appears by the end of the first affected slot. A wrong underrun state shows on `underrun_o` one cycle after the empty capture or the clear pulse.

// File: rtl/pcm_byte_serializer.sv
module pcm_byte_serializer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk_i,
  input  logic             word_clk_i,
  input  logic [WIDTH-1:0] fifo_data_i,
  input  logic             fifo_empty_i,
  input  logic             underrun_clr_i,
  output logic             fifo_rd_o,
  output logic             load_n_o,
  output logic             sdata_o,
  output logic             bit_sync_o,
  output logic             word_sync_o,
  output logic             underrun_o
);
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] IDLE_WORD = '1;

  logic [WIDTH-1:0] shreg;
  logic             bit_q, word_q, sdata_q, urun_q;
  logic             load_act, load_start, bit_rise;

  assign load_act   = ~(word_clk_i | bit_clk_i);
  assign load_start = load_act & (bit_q | word_q);
  assign bit_rise   = bit_clk_i & ~bit_q;

  assign fifo_rd_o   = ~word_clk_i;
  assign load_n_o    = ~load_act;
  assign bit_sync_o  = bit_clk_i;
  assign word_sync_o = ~(~word_clk_i);
  assign sdata_o     = sdata_q;
  assign underrun_o  = urun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b0;
      word_q <= 1'b0;
    end else begin
      bit_q  <= bit_clk_i;
      word_q <= word_clk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= IDLE_WORD;
      sdata_q <= 1'b1;
    end else if (load_start) begin
      shreg <= fifo_empty_i ? IDLE_WORD : fifo_data_i;
    end else if (bit_rise) begin
      sdata_q <= shreg[MSB];
      shreg   <= {shreg[MSB-1:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      urun_q <= 1'b0;
    else if (load_start && fifo_empty_i)
      urun_q <= 1'b1;
    else if (underrun_clr_i)
      urun_q <= 1'b0;
  end
endmodule

// File: rtl/pcm_byte_serializer_chk.sv
module pcm_byte_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_clk_i,
  input logic fifo_empty_i,
  input logic underrun_clr_i,
  input logic load_n_o,
  input logic sdata_o,
  input logic underrun_o
);
  p_data_moves_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> ($past(bit_clk_i) && !$past(bit_clk_i, 2)));

  p_underrun_from_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun_o) |-> $past(!load_n_o && fifo_empty_i));

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !underrun_clr_i) |=> underrun_o);

  p_underrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_clr_i && load_n_o) |=> !underrun_o);
endmodule

bind pcm_byte_serializer pcm_byte_serializer_chk i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .bit_clk_i(bit_clk_i),
  .fifo_empty_i(fifo_empty_i),
  .underrun_clr_i(underrun_clr_i),
  .load_n_o(load_n_o),
  .sdata_o(sdata_o),
  .underrun_o(underrun_o)
);

// File: tb/test_pcm_byte_serializer.sv
module test_pcm_byte_serializer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, bit_clk = 1'b0, word_clk = 1'b1;
  logic       fifo_empty = 1'b1, clr = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       rd, load_n, sdata, bit_sync, word_sync, underrun;

  pcm_byte_serializer #(.WIDTH(8)) i_pcm_byte_serializer (
    .clk(clk), .rst_n(rst_n), .bit_clk_i(bit_clk), .word_clk_i(word_clk),
    .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty), .underrun_clr_i(clr),
    .fifo_rd_o(rd), .load_n_o(load_n), .sdata_o(sdata), .bit_sync_o(bit_sync),
    .word_sync_o(word_sync), .underrun_o(underrun));

  int         n_checks = 0, n_fail = 0, bytes_seen = 0;
  bit         run_clk = 1'b0, finished = 1'b0, loaded_real = 1'b0;
  logic [7:0] fifo_q[$];
  logic [7:0] exp_q[$];
  bit         exp_idle_q[$];

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    fifo_q.push_back(b);
  endtask

  task automatic wait_bytes(input int n);
    while (bytes_seen < n) @(negedge clk);
  endtask

  // bit/word clock generator and FIFO model
  initial begin
    int p;
    p = 0;
    wait (run_clk);
    forever begin
      logic nb, nw;
      @(negedge clk);
      nb = (p % 8) < 4;
      nw = (p / 8) != 7;
      if (nw && !word_clk && loaded_real) begin
        void'(fifo_q.pop_front());
        loaded_real = 1'b0;
      end
      bit_clk  = nb;
      word_clk = nw;
      fifo_empty = (fifo_q.size() == 0);
      fifo_data  = fifo_empty ? 8'h00 : fifo_q[0];
      if (p == 60) begin
        loaded_real = !fifo_empty;
        exp_q.push_back(fifo_empty ? 8'hFF : fifo_data);
        exp_idle_q.push_back(fifo_empty);
      end
      p = (p + 1) % 64;
    end
  end

  // monitor / scoreboard
  initial begin
    logic pb, pw, ps, active;
    logic [7:0] acc, e;
    int nbit;
    bit idle;
    pb = 1'b0; pw = 1'b1; ps = 1'b1; active = 1'b0; acc = 8'h00; nbit = 0;
    wait (run_clk);
    forever begin
      @(posedge clk);
      #2;
      check(bit_sync === bit_clk, "R1 bit sync", {7'b0, bit_sync}, {7'b0, bit_clk});
      check(word_sync === word_clk, "R2 word sync", {7'b0, word_sync}, {7'b0, word_clk});
      check(rd === ~word_clk, "R3 read strobe", {7'b0, rd}, {7'b0, ~word_clk});
      check(load_n === (word_clk | bit_clk), "R4 load enable", {7'b0, load_n}, {7'b0, word_clk | bit_clk});
      if (bit_sync && !pb) begin
        if (word_sync && !pw) begin
          acc = {7'b0, sdata}; nbit = 1; active = 1'b1;
        end else if (active) begin
          acc = {acc[6:0], sdata}; nbit++;
        end
        if (active && nbit == 8) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected byte", acc, 8'h00);
          end else begin
            e = exp_q.pop_front();
            idle = exp_idle_q.pop_front();
            check(acc === e, idle ? "R7 idle byte" : "R6 byte MSB first", acc, e);
          end
          active = 1'b0;
          bytes_seen++;
        end
      end else begin
        check(sdata === ps, "R5 hold between rises", {7'b0, sdata}, {7'b0, ps});
      end
      pb = bit_sync; pw = word_sync; ps = sdata;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog: bytes seen actual=%0d expected=14", bytes_seen);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sdata === 1'b1, "R9 reset data", {7'b0, sdata}, 8'h01);
    check(underrun === 1'b0, "R9 reset flag", {7'b0, underrun}, 8'h00);
    rst_n = 1'b1;
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h00);
    push_byte(8'hFF); push_byte(8'h81); push_byte(8'h7E);
    run_clk = 1'b1;
    @(negedge clk);
    check(sdata === 1'b1, "R9 idle before first load", {7'b0, sdata}, 8'h01);
    wait_bytes(6);
    @(negedge clk);
    check(underrun === 1'b0, "R8 no underrun while fed", {7'b0, underrun}, 8'h00);
    wait_bytes(8);
    @(negedge clk);
    check(underrun === 1'b1, "R7 underrun raised", {7'b0, underrun}, 8'h01);
    push_byte(8'h5A); push_byte(8'hC3); push_byte(8'h96); push_byte(8'h69);
    wait_bytes(9);
    @(negedge clk);
    check(underrun === 1'b1, "R8 flag sticky", {7'b0, underrun}, 8'h01);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    check(underrun === 1'b0, "R8 flag cleared", {7'b0, underrun}, 8'h00);
    wait_bytes(14);
    @(negedge clk);
    summary();
  end
endmodule